// File: doc/BRIEF.md
# Paged Packet Buffer Diagnostic Port

This block lets software inspect and rewrite the on-chip packet buffer for diagnostics. The buffer holds 128-bit lines. Software reaches it with 32-bit accesses on a simple register bus. A page register picks one 4 KB slice of the buffer, and a fixed 4 KB address window on the bus maps onto that slice.

A line is written as four 32-bit words. The first three words wait in a staging register. The fourth word moves the whole line into memory in one write. Reads return one 32-bit word of the addressed line, one cycle after the request.

The block also holds the boundary between the receive region, which always starts at line 0, and the transmit region above it. A query port reports which region a given line belongs to.

Top module: `pbuf_diag_port`

## Requirements
- R1: A line is written by writing its four words at window offsets 0x0, 0x4, 0x8 and 0xC. Address bits 3:2 give the word index, and word 0 is line bits 31:0. Memory is written only when word 3 is written. The stored line is the three staged words with the word-3 data on top.
- R2: Until word 3 of a line has been written, a read of that line returns its earlier contents.
- R3: A commit clears the staging register. If a later commit writes only word 3, words 0 to 2 of that line become zero.
- R4: The window is bus addresses 0x1000 to 0x1FFF. The line addressed is page × 256 + address bits 11:4. All NUM_LINES lines can be reached, 3072 by default (48 KB).
- R5: The page register sits at address 0x000 and holds the page in bits 5:0. It resets to 0. Bits 31:6 read as zero.
- R6: A page write whose bits 5:0 exceed NUM_LINES/256 − 1 (0x0B by default) is ignored, and the page register keeps its value.
- R7: Every read raises bus_rvalid one cycle after bus_rd, with bus_rdata valid in that cycle. A read of an address that is neither a register nor in the window returns zero. With no read, bus_rvalid stays low.
- R8: The boundary register sits at address 0x004. It holds the receive region size in lines and resets to RX_LINES_RST. The default is 2176 lines (34 KB receive, 14 KB transmit). A write greater than NUM_LINES is ignored.
- R9: One cycle after query_line is applied, query_tx is 1 if that line is at or above the boundary (transmit region) and 0 if it is below it (receive region).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (14) | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| query_line | input | LINE_AW | Line number to classify |
| query_tx | output | 1 | 1 = transmit region, 0 = receive region (registered) |

## Verification
The assertions check on every cycle that:
- the page and boundary registers stay within their legal ranges;
- an illegal page write leaves the page unchanged;
- the read-valid strobe follows each read by exactly one cycle;
- the staging register is empty after every commit;
- the region flag matches the line and boundary of the previous cycle.

Data integrity needs the bench's scenarios:
- every line on every page is written and read back to confirm page-plus-offset addressing;
- a partly written line is read to show it is unchanged;
- a commit of word 3 alone shows the staging register was cleared;
- the region query is swept across several boundary settings.

// File: rtl/pbuf_diag_pkg.sv
package pbuf_diag_pkg;
  localparam int WORD_W         = 32;
  localparam int WORDS_PER_LINE = 4;
  localparam int LINE_W         = WORD_W * WORDS_PER_LINE;
  localparam int WSEL_W         = $clog2(WORDS_PER_LINE);

  typedef enum logic [1:0] {
    RSRC_NONE = 2'd0,
    RSRC_MEM  = 2'd1,
    RSRC_REG  = 2'd2
  } rsrc_e;
endpackage

// File: rtl/pbuf_line_ram.sv
module pbuf_line_ram #(
  parameter int DEPTH = 3072,
  parameter int AW    = 12,
  parameter int DW    = 128
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Read-first single clock, inferable as block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pbuf_stage.sv
module pbuf_stage
  import pbuf_diag_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [WSEL_W-1:0]                   word_sel,
  input  logic [WORD_W-1:0]                   wdata,
  output logic                                commit,
  output logic [LINE_W-1:0]                   commit_data,
  output logic [(WORDS_PER_LINE-1)*WORD_W-1:0] stage_flat
);
  localparam int LAST = WORDS_PER_LINE - 1;

  assign commit = wr_en && (word_sel == WSEL_W'(LAST));

  for (genvar w = 0; w < LAST; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst || commit)
        word_q <= '0;
      else if (wr_en && word_sel == WSEL_W'(w))
        word_q <= wdata;
    end
    assign commit_data[w*WORD_W +: WORD_W] = word_q;
    assign stage_flat[w*WORD_W +: WORD_W]  = word_q;
  end

  assign commit_data[LAST*WORD_W +: WORD_W] = wdata;
endmodule

// File: rtl/pbuf_cfg_regs.sv
module pbuf_cfg_regs #(
  parameter int NUM_LINES      = 3072,
  parameter int LINES_PER_PAGE = 256,
  parameter int RX_LINES_RST   = 2176,
  parameter int PAGE_W         = 6,
  parameter int LINE_AW        = 12,
  parameter int BND_W          = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               page_we,
  input  logic               bnd_we,
  input  logic [31:0]        wdata,
  input  logic [LINE_AW-1:0] query_line,
  output logic [PAGE_W-1:0]  page_q,
  output logic [BND_W-1:0]   bnd_q,
  output logic               query_tx
);
  localparam logic [PAGE_W-1:0] MAX_PAGE = PAGE_W'(NUM_LINES / LINES_PER_PAGE - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q   <= '0;
      bnd_q    <= BND_W'(RX_LINES_RST);
      query_tx <= 1'b0;
    end else begin
      if (page_we && wdata[PAGE_W-1:0] <= MAX_PAGE)
        page_q <= wdata[PAGE_W-1:0];
      if (bnd_we && wdata <= 32'(NUM_LINES))
        bnd_q <= wdata[BND_W-1:0];
      query_tx <= (32'(query_line) >= 32'(bnd_q));
    end
  end
endmodule

// File: rtl/pbuf_diag_port.sv
module pbuf_diag_port
  import pbuf_diag_pkg::*;
#(
  parameter int NUM_LINES      = 3072,
  parameter int LINES_PER_PAGE = 256,
  parameter int RX_LINES_RST   = 2176,
  parameter int ADDR_W         = 14,
  parameter int PAGE_W         = 6,
  parameter int LINE_AW        = $clog2(NUM_LINES),
  parameter int BND_W          = $clog2(NUM_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [LINE_AW-1:0] query_line,
  output logic               query_tx
);
  localparam int OFF_W    = $clog2(LINES_PER_PAGE);
  localparam int WIN_BITS = OFF_W + 4;
  localparam int FULL_W   = PAGE_W + OFF_W;
  localparam logic [ADDR_W-1:0] PAGE_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] BND_ADDR  = ADDR_W'(4);

  logic                 in_win, page_we, bnd_we, wr_win, commit;
  logic [PAGE_W-1:0]    page_q;
  logic [BND_W-1:0]     bnd_q;
  logic [FULL_W-1:0]    full_line;
  logic [LINE_AW-1:0]   line_addr;
  logic [WSEL_W-1:0]    word_sel;
  logic [LINE_W-1:0]    commit_data, ram_q;
  logic [(WORDS_PER_LINE-1)*WORD_W-1:0] stage_flat;

  rsrc_e               rsrc_q;
  logic [WSEL_W-1:0]   wsel_q;
  logic [31:0]         reg_q;

  assign in_win    = (bus_addr[ADDR_W-1:WIN_BITS] == (ADDR_W-WIN_BITS)'(1));
  assign full_line = {page_q, bus_addr[WIN_BITS-1:4]};
  assign line_addr = LINE_AW'(full_line);
  assign word_sel  = bus_addr[3:2];
  assign wr_win    = bus_wr && in_win;
  assign page_we   = bus_wr && (bus_addr == PAGE_ADDR);
  assign bnd_we    = bus_wr && (bus_addr == BND_ADDR);

  pbuf_cfg_regs #(
    .NUM_LINES(NUM_LINES), .LINES_PER_PAGE(LINES_PER_PAGE),
    .RX_LINES_RST(RX_LINES_RST), .PAGE_W(PAGE_W),
    .LINE_AW(LINE_AW), .BND_W(BND_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .page_we(page_we), .bnd_we(bnd_we),
    .wdata(bus_wdata), .query_line(query_line),
    .page_q(page_q), .bnd_q(bnd_q), .query_tx(query_tx)
  );

  pbuf_stage u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_win), .word_sel(word_sel),
    .wdata(bus_wdata), .commit(commit), .commit_data(commit_data),
    .stage_flat(stage_flat)
  );

  pbuf_line_ram #(.DEPTH(NUM_LINES), .AW(LINE_AW), .DW(LINE_W)) u_ram (
    .clk(clk), .we(commit), .waddr(line_addr), .wdata(commit_data),
    .re(bus_rd && in_win), .raddr(line_addr), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsrc_q     <= RSRC_NONE;
      wsel_q     <= '0;
      reg_q      <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      wsel_q     <= word_sel;
      if (bus_rd && in_win) begin
        rsrc_q <= RSRC_MEM;
      end else if (bus_rd && bus_addr == PAGE_ADDR) begin
        rsrc_q <= RSRC_REG;
        reg_q  <= 32'(page_q);
      end else if (bus_rd && bus_addr == BND_ADDR) begin
        rsrc_q <= RSRC_REG;
        reg_q  <= 32'(bnd_q);
      end else begin
        rsrc_q <= RSRC_NONE;
      end
    end
  end

  always_comb begin
    unique case (rsrc_q)
      RSRC_MEM: bus_rdata = ram_q[wsel_q*WORD_W +: WORD_W];
      RSRC_REG: bus_rdata = reg_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pbuf_diag_port_chk.sv
module pbuf_diag_port_chk #(
  parameter int NUM_LINES      = 3072,
  parameter int LINES_PER_PAGE = 256,
  parameter int ADDR_W         = 14,
  parameter int PAGE_W         = 6,
  parameter int LINE_AW        = 12,
  parameter int BND_W          = 12,
  parameter int STG_W          = 96
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [31:0]        bus_wdata,
  input logic               bus_rvalid,
  input logic [LINE_AW-1:0] query_line,
  input logic               query_tx,
  input logic [PAGE_W-1:0]  page_q,
  input logic [BND_W-1:0]   bnd_q,
  input logic [STG_W-1:0]   stage_flat,
  input logic               commit
);
  localparam int MAX_PAGE = NUM_LINES / LINES_PER_PAGE - 1;

  assert_page_legal_R6: assert property (@(posedge clk) disable iff (rst)
    32'(page_q) <= 32'(MAX_PAGE));

  assert_page_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == '0 && 32'(bus_wdata[PAGE_W-1:0]) > 32'(MAX_PAGE))
      |=> $stable(page_q));

  assert_rvalid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  assert_rvalid_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  assert_bnd_range_R8: assert property (@(posedge clk) disable iff (rst)
    32'(bnd_q) <= 32'(NUM_LINES));

  assert_stage_clear_R3: assert property (@(posedge clk) disable iff (rst)
    commit |=> (stage_flat == '0));

  assert_query_region_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (query_tx == (32'($past(query_line)) >= 32'($past(bnd_q)))));
endmodule

bind pbuf_diag_port pbuf_diag_port_chk #(
  .NUM_LINES(NUM_LINES), .LINES_PER_PAGE(LINES_PER_PAGE), .ADDR_W(ADDR_W),
  .PAGE_W(PAGE_W), .LINE_AW(LINE_AW), .BND_W(BND_W),
  .STG_W((pbuf_diag_pkg::WORDS_PER_LINE-1)*pbuf_diag_pkg::WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .query_line(query_line),
  .query_tx(query_tx), .page_q(page_q), .bnd_q(bnd_q),
  .stage_flat(stage_flat), .commit(commit)
);

// File: tb/pbuf_diag_port_tb.sv
module pbuf_diag_port_tb;
  localparam int NL     = 768;
  localparam int RXR    = 512;
  localparam int LAW    = $clog2(NL);
  localparam int NPAGES = NL / 256;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [13:0]     bus_addr = '0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic [LAW-1:0]  query_line = '0;
  logic            query_tx;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] model [NL][4];

  always #4 clk = ~clk;

  pbuf_diag_port #(.NUM_LINES(NL), .RX_LINES_RST(RXR)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .query_line(query_line), .query_tx(query_tx)
  );

  function automatic logic [31:0] pat(int line, int w);
    return 32'(line * 32'h0100_0193 + w * 32'h9E37 + 32'h5A5A_0000);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [13:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [13:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  function automatic logic [13:0] waddr(int line, int w);
    return 14'(32'h1000 + (line % 256) * 16 + w * 4);
  endfunction

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R7 rvalid idle after reset", 32'(bus_rvalid), 0);
    rd(14'h000, d, v); check("R5 page reset", d, 0);
    check("R7 rvalid on read", 32'(v), 1);
    rd(14'h004, d, v); check("R8 boundary reset", d, RXR);

    // R1 R4: write every line on every page, then read back every word
    for (int p = 0; p < NPAGES; p++) begin
      wr(14'h000, 32'(p));
      for (int l = 0; l < 256; l++)
        for (int w = 0; w < 4; w++) begin
          wr(waddr(l, w), pat(p * 256 + l, w));
          model[p * 256 + l][w] = pat(p * 256 + l, w);
        end
    end
    for (int p = 0; p < NPAGES; p++) begin
      wr(14'h000, 32'(p));
      for (int l = 0; l < 256; l++)
        for (int w = 0; w < 4; w++) begin
          rd(waddr(l, w), d, v);
          check("R1 R4 line readback", d, model[p * 256 + l][w]);
        end
    end

    // R2: partial write leaves the line unchanged
    wr(14'h000, 32'd1);
    for (int w = 0; w < 3; w++) wr(waddr(5, w), 32'hC0DE_0000 + 32'(w));
    for (int w = 0; w < 4; w++) begin
      rd(waddr(5, w), d, v);
      check("R2 old value before word 3", d, model[256 + 5][w]);
    end
    wr(waddr(5, 3), 32'hC0DE_0003);
    for (int w = 0; w < 4; w++) begin
      rd(waddr(5, w), d, v);
      check("R1 commit on word 3", d, 32'hC0DE_0000 + 32'(w));
    end

    // R3: staging cleared by the commit above
    wr(waddr(6, 3), 32'hBEEF_0003);
    for (int w = 0; w < 3; w++) begin
      rd(waddr(6, w), d, v);
      check("R3 staging cleared", d, 0);
    end
    rd(waddr(6, 3), d, v); check("R3 word 3 alone", d, 32'hBEEF_0003);

    // R6: illegal pages ignored
    wr(14'h000, 32'(NPAGES));
    rd(14'h000, d, v); check("R6 page above max ignored", d, 1);
    wr(14'h000, 32'h3F);
    rd(14'h000, d, v); check("R6 page 3F ignored", d, 1);
    rd(waddr(7, 0), d, v); check("R6 window still page 1", d, model[256 + 7][0]);
    // R5: reserved bits read zero
    wr(14'h000, 32'hFFFF_FFC2);
    rd(14'h000, d, v); check("R5 reserved bits zero", d, 2);

    // R7: unmapped read returns zero, rvalid drops after
    rd(14'h0800, d, v); check("R7 unmapped read zero", d, 0);
    check("R7 unmapped rvalid", 32'(v), 1);
    @(negedge clk); check("R7 rvalid low when idle", 32'(bus_rvalid), 0);

    // R8: boundary writes
    wr(14'h004, 32'(NL + 1));
    rd(14'h004, d, v); check("R8 oversize boundary ignored", d, RXR);

    // R9: region sweep across boundaries
    for (int b = 0; b < 5; b++) begin
      int bv;
      bv = (b == 0) ? RXR : (b == 1) ? 0 : (b == 2) ? 100 : (b == 3) ? NL : 1;
      if (b != 0) begin
        wr(14'h004, 32'(bv));
        rd(14'h004, d, v); check("R8 boundary write", d, 32'(bv));
      end
      for (int q = 0; q < NL; q++) begin
        @(negedge clk); query_line = LAW'(q);
        @(negedge clk);
        check("R9 region flag", 32'(query_tx), (q >= bv) ? 32'd1 : 32'd0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule